// File: doc/BRIEF.md
# Multi-Lane Candidate Frame Packer

This block takes the list of track candidates for one bunch crossing and spreads it over the 16-bit parallel words of a bank of serializer lanes. Each candidate is 32 bits wide and travels as two 16-bit words, with the upper half sent first. The lanes run from a clock that is a multiple of the 40 MHz crossing clock. In the slow setting the lane clock is 80 MHz, which gives two words per lane per crossing. In the fast setting it is 120 MHz, which gives three words per lane per crossing. A dual-crossing mode stretches one frame over two crossings so that more candidates can be carried.

The upstream sorter offers a candidate list by raising `xing_valid`. The block takes the list on a clock edge where `xing_ready` is also high. `xing_ready` is high while no frame is being sent, and during the last word of a frame. An offer made while `xing_ready` is low is dropped. The list is not kept, and nothing about the frame in progress changes. The sorter cannot stall the lanes, so this is the only form of back-pressure. In single-crossing use a new offer arrives every crossing, on the last word of the previous frame. In dual-crossing use the offer made in the middle of a frame is dropped on purpose.

Capacity per frame:

| Rate | Crossings per frame | Words per lane | Candidates |
|------|---------------------|----------------|------------|
| Slow (80 MHz) | 1 | 2 | 12 |
| Slow (80 MHz) | 2 | 4 | 24 |
| Fast (120 MHz) | 1 | 3 | 18 |
| Fast (120 MHz) | 2 | 6 | 36 |

A candidate is called "late" when its upper word goes out in the second crossing of a dual-crossing frame. A late candidate has its wire-group field overwritten with 255. Every word slot that has no valid candidate sends an idle word, with the lane's idle flag raised.

Top module: `cand_frame_packer`

## Requirements
- R1: After reset, every lane shows the idle word 16'hC5C5 with its idle flag at 1, and `xing_ready` is 1.
- R2: When `xing_valid` and `xing_ready` are both 1 on a clock edge, the block takes the list, the rate and the mode. Word 0 of the new frame appears on the lanes in the cycle right after that edge.
- R3: A frame lasts 2 cycles (slow, single), 3 cycles (fast, single), 4 cycles (slow, dual) or 6 cycles (fast, dual). If no new list is taken, all lanes are idle from the following cycle on.
- R4: In slow single mode, candidate c (0..11) goes on lane c: bits [31:16] in word 0, then bits [15:0] in word 1. Valid bits of candidates 12..35 are ignored.
- R5: In fast single mode, candidates 0..11 are placed as in R4. Candidate 12+j (j = 0..5) uses word 2: its upper half on lane 2j and its lower half on lane 2j+1. Candidates 18..35 are ignored.
- R6: In dual mode, candidate c goes on lane c mod 12. Its upper half is in word 2*(c div 12) and its lower half in the word after that. Up to 24 candidates are carried at the slow rate and up to 36 at the fast rate.
- R7: In dual mode, a candidate whose upper-word index is at least the words-per-crossing count (2 slow, 3 fast) is sent with bits [23:16] = 8'hFF. This field is bits [7:0] of its upper word. Its other bits, and all other candidates, are sent unchanged.
- R8: A word slot whose candidate valid bit is 0 carries 16'hC5C5 with idle flag 1. A slot with a valid candidate has idle flag 0.
- R9: `xing_ready` is 0 during every word of a frame except the last. An offer made while it is 0 leaves the lanes, the stored list and the frame timing unchanged.
- R10: A change of `rate_fast`, `two_xing` or the list in the middle of a frame has no effect on that frame.
- R11: An offer taken during the last word of a frame starts the next frame in the very next cycle, with no idle gap between the frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_valid | input | 1 | A candidate list is offered for this crossing |
| xing_ready | output | 1 | An offer is taken on this edge |
| rate_fast | input | 1 | 1: three words per crossing; 0: two |
| two_xing | input | 1 | 1: the frame spans two crossings |
| cand_data | input | 1152 | 36 candidates of 32 bits; candidate c is in bits [32c+31:32c] |
| cand_vld | input | 36 | Valid bit for each candidate |
| lane_data | output | 192 | 12 lane words; lane l is in bits [16l+15:16l] |
| lane_idle | output | 12 | Idle/control flag for each lane |

## Verification
Some properties are checked by assertions on every cycle:
- a taken offer restarts the word counter, which then steps once per cycle and never passes the frame length;
- the frame settings and the stored list stay frozen between takes;
- a lane flagged idle carries the idle word;
- no lane is active between frames.

Other properties only the directed scenarios can show:
- which candidate half lands in which lane and word for each of the four rate and mode pairs;
- the 255 wire-group mark on late candidates;
- that a dropped mid-frame offer really leaves the frame alone;
- the gap-free joining of two frames.

// File: rtl/cfp_pkg.sv
`timescale 1ns/1ps
package cfp_pkg;
  localparam int WORD_W   = 16;
  localparam int CAND_W   = 32;
  localparam int WG_LSB   = 16;   // wire-group field inside the candidate
  localparam int WG_W     = 8;
  localparam int WG_POS   = WG_LSB - WORD_W; // position inside the upper word
  localparam logic [WG_W-1:0] WG_MARK = '1;
  localparam int WPC_SLOW = 2;    // words per crossing, 80 MHz lanes
  localparam int WPC_FAST = 3;    // words per crossing, 120 MHz lanes

  typedef struct packed {
    logic fast;
    logic dual;
  } frame_cfg_t;

  function automatic int words_per_xing(frame_cfg_t c);
    return c.fast ? WPC_FAST : WPC_SLOW;
  endfunction

  function automatic int frame_words(frame_cfg_t c);
    return words_per_xing(c) * (c.dual ? 2 : 1);
  endfunction

  function automatic int cand_capacity(frame_cfg_t c, int n_lanes);
    return (n_lanes * frame_words(c)) / 2;
  endfunction
endpackage

// File: rtl/cfp_frame_ctrl.sv
`timescale 1ns/1ps
module cfp_frame_ctrl
  import cfp_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xing_valid,
  input  frame_cfg_t       cfg_in,
  output logic             xing_ready,
  output logic             capture,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output frame_cfg_t       cfg_q
);
  logic [CNT_W-1:0] last_idx;
  logic             at_last;

  assign last_idx   = CNT_W'(frame_words(cfg_q) - 1);
  assign at_last    = active && (cnt == last_idx);
  assign xing_ready = !active || at_last;
  assign capture    = xing_valid && xing_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      cfg_q  <= '0;
    end else if (capture) begin
      active <= 1'b1;
      cnt    <= '0;
      cfg_q  <= cfg_in;
    end else if (active) begin
      if (at_last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2: a take restarts the frame at word 0
  a_r2_take_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (active && cnt == '0));

  // R9/R10: mid-frame the counter steps and settings stay frozen
  a_r9_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !xing_ready) |=>
      (active && cnt == $past(cnt) + CNT_W'(1) && cfg_q == $past(cfg_q)));

  // R3: the counter never passes the frame length
  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(cnt) < frame_words(cfg_q)));
endmodule

// File: rtl/cfp_cand_store.sv
`timescale 1ns/1ps
module cfp_cand_store
  import cfp_pkg::*;
#(
  parameter int N_LANES = 12,
  parameter int N_CAND  = 36
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           capture,
  input  frame_cfg_t                     cfg_in,
  input  logic [N_CAND-1:0][CAND_W-1:0]  cand_in,
  input  logic [N_CAND-1:0]              vld_in,
  output logic [N_CAND-1:0][CAND_W-1:0]  cand_q,
  output logic [N_CAND-1:0]              vld_q
);
  for (genvar c = 0; c < N_CAND; c++) begin : g_slot
    logic fits;
    assign fits = (c < cand_capacity(cfg_in, N_LANES));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[c]  <= 1'b0;
        cand_q[c] <= '0;
      end else if (capture) begin
        vld_q[c]  <= vld_in[c] && fits;
        cand_q[c] <= cand_in[c];
      end
    end
  end

  // R10: the stored list only changes on a take
  a_r10_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(vld_q) && $stable(cand_q)));
endmodule

// File: rtl/cfp_lane_mux.sv
`timescale 1ns/1ps
module cfp_lane_mux
  import cfp_pkg::*;
#(
  parameter int N_LANES = 12,
  parameter int LANE    = 0,
  parameter int N_CAND  = 36,
  parameter int CNT_W   = 3,
  parameter logic [WORD_W-1:0] IDLE_WORD = 16'hC5C5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           active,
  input  logic [CNT_W-1:0]               cnt,
  input  frame_cfg_t                     cfg,
  input  logic [N_CAND-1:0][CAND_W-1:0]  cand,
  input  logic [N_CAND-1:0]              vld,
  output logic [WORD_W-1:0]              word,
  output logic                           idle
);
  localparam int IDX_W = $clog2(N_CAND);

  int                slot;
  int                pos;
  logic              low;
  logic              late;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [CAND_W-1:0] picked;
  logic [WORD_W-1:0] half;

  always_comb begin
    slot = int'(cnt);
    if (cfg.fast && !cfg.dual && slot == WPC_FAST - 1) begin
      // odd third word: one candidate is split over a lane pair
      pos = N_LANES + LANE / 2;
      low = (LANE % 2) == 1;
    end else begin
      pos = (slot / 2) * N_LANES + LANE;
      low = (slot % 2) == 1;
    end
    idx    = (pos < N_CAND) ? IDX_W'(pos) : '0;
    picked = cand[idx];
    late   = cfg.dual && !low && (slot >= words_per_xing(cfg));
    hit    = active && (pos < N_CAND) && vld[idx];
    half   = low ? picked[WORD_W-1:0] : picked[CAND_W-1:WORD_W];
    if (late) half[WG_POS +: WG_W] = WG_MARK;
    word = hit ? half : IDLE_WORD;
    idle = !hit;
  end

  // R8: an idle lane carries the idle word
  a_r8_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (word == IDLE_WORD));
endmodule

// File: rtl/cand_frame_packer.sv
`timescale 1ns/1ps
module cand_frame_packer
  import cfp_pkg::*;
#(
  parameter int N_LANES = 12,
  parameter logic [15:0] IDLE_WORD = 16'hC5C5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          xing_valid,
  output logic                          xing_ready,
  input  logic                          rate_fast,
  input  logic                          two_xing,
  input  logic [3*N_LANES*32-1:0]       cand_data,
  input  logic [3*N_LANES-1:0]          cand_vld,
  output logic [N_LANES*16-1:0]         lane_data,
  output logic [N_LANES-1:0]            lane_idle
);
  localparam int N_CAND = N_LANES * 2 * WPC_FAST / 2;
  localparam int CNT_W  = $clog2(2 * WPC_FAST);

  frame_cfg_t                    cfg_in, cfg_q;
  logic                          capture, active;
  logic [CNT_W-1:0]              cnt;
  logic [N_CAND-1:0][CAND_W-1:0] cand_in, cand_q;
  logic [N_CAND-1:0]             vld_q;

  assign cfg_in  = '{fast: rate_fast, dual: two_xing};
  assign cand_in = cand_data;

  cfp_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid), .cfg_in(cfg_in),
    .xing_ready(xing_ready), .capture(capture), .active(active),
    .cnt(cnt), .cfg_q(cfg_q)
  );

  cfp_cand_store #(.N_LANES(N_LANES), .N_CAND(N_CAND)) u_store (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cfg_in(cfg_in),
    .cand_in(cand_in), .vld_in(cand_vld), .cand_q(cand_q), .vld_q(vld_q)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    cfp_lane_mux #(
      .N_LANES(N_LANES), .LANE(l), .N_CAND(N_CAND),
      .CNT_W(CNT_W), .IDLE_WORD(IDLE_WORD)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .active(active), .cnt(cnt), .cfg(cfg_q),
      .cand(cand_q), .vld(vld_q),
      .word(lane_data[l*WORD_W +: WORD_W]), .idle(lane_idle[l])
    );
  end

  // R3: no lane is active between frames
  a_r3_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&lane_idle));
endmodule

// File: tb/cand_frame_packer_tb.sv
`timescale 1ns/1ps
module cand_frame_packer_tb;
  localparam int NL = 12;
  localparam int NC = 36;
  localparam logic [15:0] IDLE = 16'hC5C5;

  logic clk = 0;
  logic rst_n = 0;
  logic xing_valid = 0;
  logic xing_ready;
  logic rate_fast = 0;
  logic two_xing = 0;
  logic [NC*32-1:0] cand_data = '0;
  logic [NC-1:0] cand_vld = '0;
  logic [NL*16-1:0] lane_data;
  logic [NL-1:0] lane_idle;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] exp_d [NL][6];
  logic        exp_i [NL][6];

  always #2.5 clk = ~clk;

  cand_frame_packer u_dut (
    .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid), .xing_ready(xing_ready),
    .rate_fast(rate_fast), .two_xing(two_xing), .cand_data(cand_data),
    .cand_vld(cand_vld), .lane_data(lane_data), .lane_idle(lane_idle)
  );

  function automatic logic [31:0] cval(int seed, int c);
    return (32'(seed) * 32'h0100_0193) ^ {8'(c), ~8'(c), 8'(c * 7), 8'h3C};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_list(bit r, bit tx, int seed, logic [NC-1:0] m);
    for (int c = 0; c < NC; c++) cand_data[c*32 +: 32] = cval(seed, c);
    cand_vld   = m;
    rate_fast  = r;
    two_xing   = tx;
    xing_valid = 1'b1;
  endtask

  task automatic put(int lane, int w, logic [15:0] d);
    exp_d[lane][w] = d;
    exp_i[lane][w] = 1'b0;
  endtask

  // expected layout built from the requirements
  task automatic build_exp(bit r, bit tx, int seed, logic [NC-1:0] m);
    int wpx = r ? 3 : 2;
    int fw  = wpx * (tx ? 2 : 1);
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < 6; w++) begin exp_d[l][w] = IDLE; exp_i[l][w] = 1'b1; end
    for (int c = 0; c < NL * fw / 2; c++) begin
      logic [31:0] v = cval(seed, c);
      if (!m[c]) continue;
      if (r && !tx && c >= NL) begin
        put(2 * (c - NL), 2, v[31:16]);          // R5 split pair
        put(2 * (c - NL) + 1, 2, v[15:0]);
      end else begin
        int u = 2 * (c / NL);
        if (tx && u >= wpx) v[23:16] = 8'hFF;    // R7 late mark
        put(c % NL, u, v[31:16]);
        put(c % NL, u + 1, v[15:0]);
      end
    end
  endtask

  task automatic check_word(int w, int fw, string req);
    for (int l = 0; l < NL; l++) begin
      check(req, 32'(lane_data[l*16 +: 16]), 32'(exp_d[l][w]), $sformatf("lane %0d word %0d data", l, w));
      check(req, 32'(lane_idle[l]), 32'(exp_i[l][w]), $sformatf("lane %0d word %0d idle", l, w));
    end
    check("R9", 32'(xing_ready), 32'(w == fw - 1), $sformatf("ready at word %0d", w));
  endtask

  task automatic check_quiet(string req);
    check(req, 32'(lane_idle), 32'({NL{1'b1}}), "all idle flags");
    for (int l = 0; l < NL; l++)
      check(req, 32'(lane_data[l*16 +: 16]), 32'(IDLE), $sformatf("lane %0d idle word", l));
    check(req, 32'(xing_ready), 32'd1, "ready when quiet");
  endtask

  task automatic play(bit r, bit tx, int seed, logic [NC-1:0] m, string req);
    int fw = (r ? 3 : 2) * (tx ? 2 : 1);
    @(negedge clk);
    drive_list(r, tx, seed, m);
    build_exp(r, tx, seed, m);
    @(negedge clk);
    xing_valid = 1'b0;
    for (int w = 0; w < fw; w++) begin
      check_word(w, fw, req);
      if (w < fw - 1) @(negedge clk);
    end
    @(negedge clk);
    check_quiet("R3");
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_quiet("R1");
  endtask

  task automatic t_slow_single;  play(0, 0, 11, '1, "R4"); endtask
  task automatic t_fast_single;  play(1, 0, 23, '1, "R5"); endtask
  task automatic t_slow_dual;    play(0, 1, 37, '1, "R6_R7"); endtask
  task automatic t_fast_dual;    play(1, 1, 41, '1, "R6_R7"); endtask
  task automatic t_sparse;       play(1, 0, 53, 36'h0_A5F_3C1, "R8"); endtask
  task automatic t_sparse_dual;  play(1, 1, 59, 36'h9_0F0_8421, "R8"); endtask

  task automatic t_drop_midframe;
    @(negedge clk);
    drive_list(0, 1, 67, '1);
    build_exp(0, 1, 67, '1);
    @(negedge clk);
    xing_valid = 1'b0;
    check_word(0, 4, "R6");
    @(negedge clk);
    check_word(1, 4, "R6");
    drive_list(1, 0, 99, 36'h0_0000_0F0);   // offer while busy: R9 R10
    @(negedge clk);
    xing_valid = 1'b0;
    for (int w = 2; w < 4; w++) begin
      check_word(w, 4, "R10");
      if (w < 3) @(negedge clk);
    end
    @(negedge clk);
    check_quiet("R9");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    drive_list(0, 0, 71, '1);
    build_exp(0, 0, 71, '1);
    @(negedge clk);
    xing_valid = 1'b0;
    check_word(0, 2, "R11");
    @(negedge clk);
    check_word(1, 2, "R11");
    drive_list(1, 0, 83, 36'h3_FFFF_FFFF);
    build_exp(1, 0, 83, 36'h3_FFFF_FFFF);
    @(negedge clk);
    xing_valid = 1'b0;
    for (int w = 0; w < 3; w++) begin
      check_word(w, 3, "R11");
      if (w < 2) @(negedge clk);
    end
    @(negedge clk);
    check_quiet("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_slow_single();
    t_fast_single();
    t_slow_dual();
    t_fast_dual();
    t_sparse();
    t_sparse_dual();
    t_drop_midframe();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule